// File: doc/BRIEF.md
# Memory-Mapped SPI Master Controller

This block is an SPI bus master that a host drives through a small synchronous register port. The host sets clock polarity, clock phase, word length and a clock divider in a control register, then writes a word to the data register. That write starts a full-duplex shift: the outgoing word leaves on the serial output, most significant bit first, while a word of the same length is collected from the serial input. When the shift ends, the received word is latched into the data register and a flag tells the host that it is ready to read.

There is a single holding word and no queue. A host that only wants to receive writes a zero word to generate the clocks. Clearing the enable bit stops the core at once, and that is also how a host ends a burst. One level-sensitive interrupt line combines two separately enabled sources: a received word is waiting, or the shifter is idle and ready for a new word.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset the control register, status register and data register all read 0x0000, and `spi_sclk`, `spi_mosi` and `irq` are all low.
- R2: The data register is at address 0, the control register at address 2 and the status register at address 4. In the control register, bit 0 is enable, bit 2 is 16-bit word length, bit 5 is the receive interrupt enable, bit 6 is the ready interrupt enable, bit 7 is CPOL, bit 8 is CPHA and bits 15:9 are the divider N. The other bits read as zero. A write with `bus_wide`=0 changes only bits 7:0 of the addressed register.
- R3: While a word shifts, each half-period of `spi_sclk` lasts N+1 clock cycles, and N=0 behaves as N=1. A word takes 2·bits·(N+1) cycles from the write to the drop of busy.
- R4: `spi_sclk` rests at the CPOL level. With CPHA=0, data is sampled on the leading edge of each bit and the output changes on the trailing edge. With CPHA=1, the output changes on the leading edge and data is sampled on the trailing edge.
- R5: With control bit 2 clear, 8 bits shift and the received word reads back with bits 15:8 at zero. With the bit set, 16 bits shift.
- R6: Each shift sends the transmit word MSB first on `spi_mosi` and stores the bits seen on `spi_miso`, MSB first, as the received word.
- R7: Status bit 0 is high while a word shifts. Status bit 1 rises when a shift completes. A read of the data register clears bit 1. A completed word overwrites an unread one.
- R8: A write to the data register is ignored while enable is clear or while a word is shifting.
- R9: Clearing enable during a shift ends it in the next cycle. Busy drops, `spi_sclk` returns to idle and status bit 1 is not set.
- R10: `irq` equals (status bit 1 AND receive interrupt enable) OR (NOT busy AND ready interrupt enable AND enable).
- R11: `spi_mosi` is low whenever no word is shifting.
- R12: A data register write with `bus_wide`=0 transmits `{8'h00, bus_wdata[7:0]}`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (data reads clear the ready flag) |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 16 | Write data |
| bus_wide | input | 1 | 1 for a 16-bit access, 0 for an 8-bit access |
| bus_rdata | output | 16 | Read data of the addressed register (combinational) |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| irq | output | 1 | Level interrupt request |

## Verification
Some rules are checked on every cycle. The serial output stays low when the core is idle, and the clock rests at its polarity level. The ready flag rises only on a shift-completion strobe. A disabled core never starts, and an abort clears busy in the next cycle. A pending flag with its enable set always drives the interrupt. In 8-bit mode, the upper byte of a completed word is zero. Other behaviour can only be shown by the bench's scenarios: the exact clock timing for each divider value, the sampling and launching edges in all four modes, full-duplex data integrity, overwrite of an unread word, and ignored writes. A behavioural model checks these against clock, data and interrupt on every cycle while a slave model answers on the serial input.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
    localparam int WORD_W     = 16;
    localparam int HALF_W     = WORD_W / 2;
    localparam int DIV_W      = 7;
    localparam int BIT_EN     = 0;
    localparam int BIT_WIDE   = 2;
    localparam int BIT_EIR    = 5;
    localparam int BIT_EIW    = 6;
    localparam int BIT_CPOL   = 7;
    localparam int BIT_CPHA   = 8;
    localparam int DIV_LSB    = 9;
    localparam int REG_DATA   = 0;
    localparam int REG_CTRL   = 2;
    localparam int REG_STAT   = 4;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             cpha;
        logic             cpol;
        logic             eiw;
        logic             eir;
        logic             wide;
        logic             en;
    } ctrl_t;

    function automatic ctrl_t word_to_ctrl(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.en   = w[BIT_EN];
        c.wide = w[BIT_WIDE];
        c.eir  = w[BIT_EIR];
        c.eiw  = w[BIT_EIW];
        c.cpol = w[BIT_CPOL];
        c.cpha = w[BIT_CPHA];
        c.div  = w[DIV_LSB +: DIV_W];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_to_word(input ctrl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[BIT_EN]            = c.en;
        w[BIT_WIDE]          = c.wide;
        w[BIT_EIR]           = c.eir;
        w[BIT_EIW]           = c.eiw;
        w[BIT_CPOL]          = c.cpol;
        w[BIT_CPHA]          = c.cpha;
        w[DIV_LSB +: DIV_W]  = c.div;
        return w;
    endfunction
endpackage

// File: rtl/spi_host_baud.sv
module spi_host_baud
    import spi_host_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = (div == '0) ? DIV_W'(1) : div;
        tick  = run && (cnt_q == limit);
        if (!run || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/spi_host_shift.sv
module spi_host_shift
    import spi_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              wide,
    input  logic              cpha,
    input  logic              en,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              phase,
    output logic              mosi,
    output logic              done,
    output logic [WORD_W-1:0] rx_word
);
    localparam int EDGE_W = $clog2(2 * WORD_W);

    typedef struct packed {
        logic              busy;
        logic              phase;
        logic [EDGE_W-1:0] edge_n;
        logic [WORD_W-1:0] sr;
        logic              smp;
    } sh_t;

    sh_t s_d, s_q;
    logic [EDGE_W-1:0] last_edge;
    logic              is_last;
    logic              smp_edge;
    logic              out_edge;

    always_comb begin
        last_edge = wide ? EDGE_W'(2 * WORD_W - 1) : EDGE_W'(2 * HALF_W - 1);
        is_last   = (s_q.edge_n == last_edge);
        smp_edge  = (s_q.edge_n[0] == cpha);
        out_edge  = (s_q.edge_n[0] != cpha) && (s_q.edge_n != '0);
        s_d  = s_q;
        done = 1'b0;
        if (start) begin
            s_d.busy   = 1'b1;
            s_d.phase  = 1'b0;
            s_d.edge_n = '0;
            s_d.sr     = tx_word;
        end else if (s_q.busy && !en) begin
            s_d.busy  = 1'b0;
            s_d.phase = 1'b0;
        end else if (s_q.busy && tick) begin
            s_d.phase  = ~s_q.phase;
            s_d.edge_n = s_q.edge_n + 1'b1;
            if (smp_edge) begin
                s_d.smp = miso;
            end
            if (is_last) begin
                s_d.busy  = 1'b0;
                s_d.phase = 1'b0;
                s_d.sr    = {s_q.sr[WORD_W-2:0], cpha ? miso : s_q.smp};
                done      = 1'b1;
            end else if (out_edge) begin
                s_d.sr    = {s_q.sr[WORD_W-2:0], s_q.smp};
            end
        end
        rx_word = wide ? s_d.sr : {{(WORD_W-HALF_W){1'b0}}, s_d.sr[HALF_W-1:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy  = s_q.busy;
    assign phase = s_q.phase;
    assign mosi  = s_q.busy && (wide ? s_q.sr[WORD_W-1] : s_q.sr[HALF_W-1]);
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
    import spi_host_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_wide,
    input  logic              busy,
    input  logic              done,
    input  logic [WORD_W-1:0] rx_word,
    output ctrl_t             ctrl,
    output logic              start,
    output logic [WORD_W-1:0] tx_word,
    output logic [WORD_W-1:0] rdata,
    output logic              irq
);
    typedef struct packed {
        ctrl_t             ctrl;
        logic              rbf;
        logic [WORD_W-1:0] rx;
    } rg_t;

    rg_t r_d, r_q;
    logic hit_data, hit_ctrl, hit_stat;
    logic [WORD_W-1:0] ctrl_word;
    logic rbf_w;

    always_comb begin
        hit_data  = (bus_addr == ADDR_W'(REG_DATA));
        hit_ctrl  = (bus_addr == ADDR_W'(REG_CTRL));
        hit_stat  = (bus_addr == ADDR_W'(REG_STAT));
        ctrl_word = ctrl_to_word(r_q.ctrl);
        tx_word   = bus_wide ? bus_wdata : {{(WORD_W-HALF_W){1'b0}}, bus_wdata[HALF_W-1:0]};
        start     = bus_wr && hit_data && r_q.ctrl.en && !busy;

        r_d = r_q;
        if (bus_wr && hit_ctrl) begin
            if (bus_wide) begin
                r_d.ctrl = word_to_ctrl(bus_wdata);
            end else begin
                r_d.ctrl = word_to_ctrl({ctrl_word[WORD_W-1:HALF_W], bus_wdata[HALF_W-1:0]});
            end
        end
        if (bus_rd && hit_data) begin
            r_d.rbf = 1'b0;
        end
        if (done) begin
            r_d.rbf = 1'b1;
            r_d.rx  = rx_word;
        end

        rdata = '0;
        if (hit_data) begin
            rdata = r_q.rx;
        end else if (hit_ctrl) begin
            rdata = ctrl_word;
        end else if (hit_stat) begin
            rdata = {{(WORD_W-2){1'b0}}, r_q.rbf, busy};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rbf_w = r_q.rbf;
    assign ctrl  = r_q.ctrl;
    assign irq   = (rbf_w && r_q.ctrl.eir) || (!busy && r_q.ctrl.eiw && r_q.ctrl.en);
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_wide,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              irq
);
    ctrl_t             ctrl;
    logic              start;
    logic [WORD_W-1:0] tx_word;
    logic              busy;
    logic              phase;
    logic              done;
    logic [WORD_W-1:0] rx_word;
    logic              tick;

    spi_host_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wide  (bus_wide),
        .busy      (busy),
        .done      (done),
        .rx_word   (rx_word),
        .ctrl      (ctrl),
        .start     (start),
        .tx_word   (tx_word),
        .rdata     (bus_rdata),
        .irq       (irq)
    );

    spi_host_baud u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy && ctrl.en),
        .div   (ctrl.div),
        .tick  (tick)
    );

    spi_host_shift u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tx_word (tx_word),
        .wide    (ctrl.wide),
        .cpha    (ctrl.cpha),
        .en      (ctrl.en),
        .tick    (tick),
        .miso    (spi_miso),
        .busy    (busy),
        .phase   (phase),
        .mosi    (spi_mosi),
        .done    (done),
        .rx_word (rx_word)
    );

    assign spi_sclk = ctrl.cpol ^ phase;
endmodule

// File: rtl/spi_host_chk.sv
module spi_host_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       rbf,
    input logic       en,
    input logic       eir,
    input logic       wide,
    input logic       cpol,
    input logic       sclk,
    input logic       mosi,
    input logic       irq,
    input logic [7:0] rx_hi
);
    assert_mosi_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mosi);

    assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sclk == cpol));

    assert_rbf_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rbf) |-> $past(done));

    assert_no_start_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !busy) |=> !busy);

    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !en) |=> (!busy && !$rose(rbf)));

    assert_irq_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rbf && eir) |-> irq);

    assert_narrow_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wide) |-> (rx_hi == 8'h00));
endmodule

bind spi_host_ctrl spi_host_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .done  (done),
    .rbf   (u_regs.rbf_w),
    .en    (ctrl.en),
    .eir   (ctrl.eir),
    .wide  (ctrl.wide),
    .cpol  (ctrl.cpol),
    .sclk  (spi_sclk),
    .mosi  (spi_mosi),
    .irq   (irq),
    .rx_hi (rx_word[15:8])
);

// File: tb/spi_host_ctrl_test.sv
`timescale 1ns/1ps
module spi_host_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_wide = 1'b1;
    logic [15:0] bus_rdata;
    logic        spi_sclk, spi_mosi, irq;
    logic        spi_miso = 1'b0;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    int m_busy, m_done, m_tc, m_tx, m_rbf, m_rx, m_ctrl;
    int slv = 0;

    spi_host_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wide(bus_wide),
        .bus_rdata(bus_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .irq(irq)
    );

    always #4 clk = ~clk;

    function automatic int fld(int v, int b);
        return (v >> b) & 1;
    endfunction

    function automatic int nbits();
        return fld(m_ctrl, 2) ? 16 : 8;
    endfunction

    function automatic int bit_index();
        if (fld(m_ctrl, 8) == 1) return (m_done == 0) ? 0 : (m_done - 1) / 2;
        return m_done / 2;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // behavioural reference, advanced at every rising edge
    always @(posedge clk) begin
        int old_busy, old_en, limit, fin;
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_tc = 0; m_tx = 0; m_rbf = 0; m_rx = 0; m_ctrl = 0;
        end else begin
            old_busy = m_busy;
            old_en   = fld(m_ctrl, 0);
            limit    = (m_ctrl >> 9) & 127;
            if (limit == 0) limit = 1;
            fin = 0;
            if (m_busy != 0 && old_en == 0) begin
                m_busy = 0;
            end else if (m_busy != 0) begin
                m_tc++;
                if (m_tc == limit + 1) begin
                    m_tc = 0;
                    m_done++;
                    if (m_done == 2 * nbits()) begin
                        m_busy = 0;
                        fin = 1;
                    end
                end
            end
            if (bus_rd && bus_addr == 3'd0) m_rbf = 0;
            if (fin != 0) begin
                m_rbf = 1;
                m_rx  = (nbits() == 16) ? (slv & 16'hFFFF) : (slv & 16'h00FF);
            end
            if (bus_wr && bus_addr == 3'd2) begin
                if (bus_wide) m_ctrl = int'(bus_wdata) & 16'hFFE5;
                else m_ctrl = (m_ctrl & 16'hFF00) | (int'(bus_wdata) & 16'h00E5);
            end
            if (bus_wr && bus_addr == 3'd0 && old_en != 0 && old_busy == 0) begin
                m_busy = 1; m_done = 0; m_tc = 0;
                m_tx = bus_wide ? int'(bus_wdata) : (int'(bus_wdata) & 16'h00FF);
            end
        end
    end

    // per-cycle comparison, then slave drives its next bit
    always @(negedge clk) begin
        int k, exp_mosi, exp_sclk, exp_irq;
        k = bit_index();
        if (k >= nbits()) k = nbits() - 1;
        if (rst_n) begin
            exp_mosi = (m_busy != 0) ? fld(m_tx, nbits() - 1 - k) : 0;
            exp_sclk = fld(m_ctrl, 7) ^ ((m_busy != 0) ? (m_done & 1) : 0);
            exp_irq  = (m_rbf & fld(m_ctrl, 5)) |
                       ((m_busy == 0 ? 1 : 0) & fld(m_ctrl, 6) & fld(m_ctrl, 0));
            chk("R6 mosi", int'(spi_mosi), exp_mosi);
            chk("R3 sclk", int'(spi_sclk), exp_sclk);
            chk("R10 irq", int'(irq), exp_irq);
        end
        spi_miso = fld(slv, nbits() - 1 - k) != 0;
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input int addr, input int data, input bit wide);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'(addr); bus_wdata = 16'(data); bus_wide = wide;
        @(negedge clk);
        bus_wr = 1'b0; bus_wide = 1'b1;
    endtask

    task automatic rd(input int addr, input int exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 3'(addr);
        #1;
        chk(tag, int'(bus_rdata), exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_busy != 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 sclk", int'(spi_sclk), 0);
        chk("R1 mosi", int'(spi_mosi), 0);
        chk("R1 irq", int'(irq), 0);
        rd(2, 16'h0000, "R1 ctrl");
        rd(4, 16'h0000, "R1 stat");
        rd(0, 16'h0000, "R1 data");

        // mode 0, 8-bit, N=1
        wr(2, 16'h0201, 1);
        rd(2, 16'h0201, "R2 ctrl readback");
        slv = 16'h00A5;
        wr(0, 16'h003C, 1);
        rd(4, 16'h0001, "R7 busy");
        wait_idle();
        rd(4, 16'h0002, "R7 rbf set");
        rd(0, 16'h00A5, "R6 mode0 rx");
        rd(4, 16'h0000, "R7 rbf cleared");

        // mode 3, 16-bit, N=3
        wr(2, 16'h0785, 1);
        slv = 16'h1234;
        wr(0, 16'hBEEF, 1);
        wait_idle();
        rd(0, 16'h1234, "R4 mode3 rx");

        // mode 1, 8-bit, N=0 acts as 1
        wr(2, 16'h0101, 1);
        slv = 16'h005A;
        wr(0, 16'h00C3, 1);
        wait_idle();
        rd(0, 16'h005A, "R4 mode1 rx");

        // mode 2, 8-bit, N=2, upper byte of tx ignored
        wr(2, 16'h0481, 1);
        slv = 16'h0096;
        wr(0, 16'hAB69, 1);
        wait_idle();
        rd(0, 16'h0096, "R5 narrow rx upper zero");

        // byte write on data in 16-bit mode
        wr(2, 16'h0205, 1);
        slv = 16'h8001;
        wr(0, 16'hFF81, 0);
        wait_idle();
        rd(0, 16'h8001, "R12 byte tx wide rx");

        // write while busy is ignored
        slv = 16'h00F0;
        wr(0, 16'h1111, 1);
        wr(0, 16'h2222, 1);
        wait_idle();
        rd(4, 16'h0002, "R8 single transfer");
        rd(0, 16'h00F0, "R8 busy write ignored");

        // overwrite of an unread word
        slv = 16'h0ABC;
        wr(0, 16'h0F0F, 1);
        wait_idle();
        slv = 16'h0DEF;
        wr(0, 16'hF0F0, 1);
        wait_idle();
        rd(4, 16'h0002, "R7 rbf after two");
        rd(0, 16'h0DEF, "R7 overwrite");

        // disabled core ignores data writes
        wr(2, 16'h0204, 1);
        wr(0, 16'h5555, 1);
        repeat (10) @(negedge clk);
        rd(4, 16'h0000, "R8 disabled no start");
        chk("R11 mosi idle", int'(spi_mosi), 0);

        // abort mid-word
        wr(2, 16'h0A05, 1);
        slv = 16'hFFFF;
        wr(0, 16'hFFFF, 1);
        repeat (20) @(negedge clk);
        wr(2, 16'h0A04, 1);
        repeat (3) @(negedge clk);
        rd(4, 16'h0000, "R9 abort status");
        chk("R9 sclk idle", int'(spi_sclk), 0);

        // interrupts
        wr(2, 16'h0241, 1);
        #1;
        chk("R10 ready irq", int'(irq), 1);
        slv = 16'h0033;
        wr(0, 16'h0044, 1);
        @(negedge clk);
        chk("R10 busy irq low", int'(irq), 0);
        wait_idle();
        wr(2, 16'h0221, 1);
        #1;
        chk("R10 rx irq", int'(irq), 1);
        rd(0, 16'h0033, "R10 rx data");
        #1;
        chk("R10 irq cleared", int'(irq), 0);

        // control register byte write and reserved bits
        wr(2, 16'h7EC5, 0);
        rd(2, 16'h02C5, "R2 byte ctrl");
        wr(2, 16'hFFFE, 1);
        rd(2, 16'hFFE4, "R2 reserved zero");

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule